// File: doc/BRIEF.md
# Infrared Transceiver Mode-Select Sequencer

This block sits on the host side of a serial infrared link. It owns the two control pins of an infrared transceiver module: the shutdown/mode-select pin and the transmit-data pin. On request it moves the transceiver into its low-bandwidth receive mode (9.6 kbit/s to 1.152 Mbit/s), its high-bandwidth receive mode (4 Mbit/s), into shutdown, or back out of shutdown. The transceiver latches its receive bandwidth from the level of the transmit pin at the moment the shutdown pin falls. The sequencer therefore places every transmit-pin change around the shutdown pulse. It holds a setup window before the falling edge and a hold window after it.

Each timing window is a count of clock cycles derived from a clock-period parameter. While no sequence runs, the host's serial transmit stream passes straight through to the transmit pin. A one-cycle done pulse marks the end of each sequence. A one-cycle error pulse marks a request that was refused.

Top module: `irxcvr_modeseq`

## Requirements
- R1: While `rst_n` is low, `sd_o` and `txd_o` are low and `busy_o`, `done_o` and `err_o` are low, whatever `tx_data_i` is.
- R2: When idle (not shut down and no sequence running), `txd_o` follows `tx_data_i` combinationally and `sd_o` is low.
- R3: The request code `req_op_i` is sampled on a rising clock edge with `req_valid_i` high: 0 = low-bandwidth mode, 1 = high-bandwidth mode, 2 = shutdown, 3 = wake. Codes 0 to 2 are accepted only when idle, and code 3 only when shut down. After an accepted request, `busy_o` is high from the next cycle.
- R4: Low-bandwidth sequence: `sd_o` high with `txd_o` low for max(PULSE, SETUP) cycles. Then `sd_o` low with `txd_o` low for HOLD cycles.
- R5: High-bandwidth sequence: `sd_o` high with `txd_o` low for max(SETUP, PULSE-SETUP) cycles. Then `sd_o` high with `txd_o` high for SETUP cycles. Then `sd_o` low with `txd_o` high for HOLD cycles. After that `txd_o` is released to pass-through.
- R6: Every window is floor(time_ns / CLK_PERIOD_NS) + 1 cycles. This gives SETUP from 25 ns, HOLD from 100 ns, PULSE from 50 ns, and the shutdown and wake windows from their own parameters (defaults 400 us and 150 us).
- R7: Shutdown request: `sd_o` high and `txd_o` low for the shutdown window while busy. The block then stays shut down with `sd_o` high, `txd_o` low and `busy_o` low.
- R8: Wake request: `sd_o` low and `txd_o` low for the wake window while busy, then idle with pass-through.
- R9: `done_o` is a single-cycle pulse in the first cycle after a sequence ends: on return to idle, or on reaching shutdown. `busy_o` is low in that cycle.
- R10: A request that arrives while busy, or whose code is not allowed in the current state, gives a one-cycle `err_o` pulse in the next cycle and leaves state and pins unchanged.
- R11: While a sequence runs or the block is shut down, `tx_data_i` has no effect on `txd_o`.
- R12: In the cycle `sd_o` falls, `txd_o` keeps the value it had in the cycle before. In any sequence, `sd_o` stays high for at least PULSE cycles before it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, sampled on the rising edge |
| req_op_i | input | 2 | Request code: 0 low-bw, 1 high-bw, 2 shutdown, 3 wake |
| tx_data_i | input | 1 | Serial transmit stream for pass-through |
| sd_o | output | 1 | Transceiver shutdown/mode-select pin |
| txd_o | output | 1 | Transceiver transmit-data pin |
| busy_o | output | 1 | High while a sequence runs |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle refused-request pulse |

## Verification
The bench counts every segment of each sequence cycle by cycle. An off-by-one window, or a transmit-pin change placed on the wrong side of the shutdown-pin fall, shows up as a length or level mismatch. Such a fault would make the transceiver latch the wrong bandwidth or violate hold. The bench injects a request partway through a high-bandwidth sequence and sends wrong-state codes: a wake while idle and a mode request while shut down. A design that accepted any of these would restart a sequence or drop the shutdown pin early. It also drives the transmit stream high during sequences and during shutdown, which catches a pass-through path that leaks onto the pin.

// File: rtl/irx_pkg.sv
package irx_pkg;

    typedef enum logic [1:0] {
        OP_LOWBW  = 2'd0,
        OP_HIGHBW = 2'd1,
        OP_SLEEP  = 2'd2,
        OP_WAKE   = 2'd3
    } req_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LB_PULSE,
        ST_LB_HOLD,
        ST_HB_LEAD,
        ST_HB_SETUP,
        ST_HB_HOLD,
        ST_SLP_ENTER,
        ST_ASLEEP,
        ST_WAKING
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       sd;
        logic       txd;
        logic       pass;
        logic       busy;
        logic       done;
        logic       err;
    } ctl_t;

    // Strictly exceeds the minimum time: floor(ns/period) + 1 cycles.
    function automatic int unsigned win_cycles(input int unsigned t_ns,
                                               input int unsigned per_ns);
        return t_ns / per_ns + 1;
    endfunction

endpackage

// File: rtl/irx_dly_timer.sv
module irx_dly_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i - W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/irx_txd_mux.sv
module irx_txd_mux (
    input  logic pass_i,
    input  logic drive_i,
    input  logic data_i,
    output logic txd_o
);
    assign txd_o = pass_i ? data_i : drive_i;
endmodule

// File: rtl/irxcvr_modeseq.sv
module irxcvr_modeseq #(
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned SETUP_NS      = 25,
    parameter int unsigned HOLD_NS       = 100,
    parameter int unsigned PULSE_NS      = 50,
    parameter int unsigned SLEEP_NS      = 400000,
    parameter int unsigned WAKE_NS       = 150000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid_i,
    input  logic [1:0] req_op_i,
    input  logic       tx_data_i,
    output logic       sd_o,
    output logic       txd_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o
);
    import irx_pkg::*;

    localparam int unsigned C_SU    = win_cycles(SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned C_HOLD  = win_cycles(HOLD_NS, CLK_PERIOD_NS);
    localparam int unsigned C_PULSE = win_cycles(PULSE_NS, CLK_PERIOD_NS);
    localparam int unsigned C_SLEEP = win_cycles(SLEEP_NS, CLK_PERIOD_NS);
    localparam int unsigned C_WAKE  = win_cycles(WAKE_NS, CLK_PERIOD_NS);
    localparam int unsigned C_LBP   = (C_PULSE > C_SU) ? C_PULSE : C_SU;
    localparam int unsigned C_LEAD  = (C_PULSE > 2 * C_SU) ? (C_PULSE - C_SU) : C_SU;
    localparam int unsigned C_M1    = (C_SLEEP > C_WAKE) ? C_SLEEP : C_WAKE;
    localparam int unsigned C_M2    = (C_HOLD > C_LBP) ? C_HOLD : C_LBP;
    localparam int unsigned C_M3    = (C_LEAD > C_SU) ? C_LEAD : C_SU;
    localparam int unsigned C_M4    = (C_M2 > C_M3) ? C_M2 : C_M3;
    localparam int unsigned C_MAX   = (C_M1 > C_M4) ? C_M1 : C_M4;
    localparam int          CW      = $clog2(C_MAX + 1);

    ctl_t          ctl_d, ctl_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_exp;

    irx_dly_timer #(.W(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    unique case (req_op_e'(req_op_i))
                        OP_LOWBW: begin
                            ctl_d.st = ST_LB_PULSE; tmr_load = 1'b1; tmr_val = CW'(C_LBP);
                        end
                        OP_HIGHBW: begin
                            ctl_d.st = ST_HB_LEAD;  tmr_load = 1'b1; tmr_val = CW'(C_LEAD);
                        end
                        OP_SLEEP: begin
                            ctl_d.st = ST_SLP_ENTER; tmr_load = 1'b1; tmr_val = CW'(C_SLEEP);
                        end
                        default: ctl_d.err = 1'b1;
                    endcase
                end
            end
            ST_ASLEEP: begin
                if (req_valid_i) begin
                    if (req_op_e'(req_op_i) == OP_WAKE) begin
                        ctl_d.st = ST_WAKING; tmr_load = 1'b1; tmr_val = CW'(C_WAKE);
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
            end
            default: begin
                ctl_d.err = req_valid_i;
                if (tmr_exp) begin
                    unique case (ctl_q.st)
                        ST_LB_PULSE: begin
                            ctl_d.st = ST_LB_HOLD; tmr_load = 1'b1; tmr_val = CW'(C_HOLD);
                        end
                        ST_HB_LEAD: begin
                            ctl_d.st = ST_HB_SETUP; tmr_load = 1'b1; tmr_val = CW'(C_SU);
                        end
                        ST_HB_SETUP: begin
                            ctl_d.st = ST_HB_HOLD; tmr_load = 1'b1; tmr_val = CW'(C_HOLD);
                        end
                        ST_SLP_ENTER: begin
                            ctl_d.st = ST_ASLEEP; ctl_d.done = 1'b1;
                        end
                        default: begin
                            ctl_d.st = ST_IDLE; ctl_d.done = 1'b1;
                        end
                    endcase
                end
            end
        endcase

        // Pin and handshake levels follow the state being entered.
        unique case (ctl_d.st)
            ST_IDLE:      begin ctl_d.sd = 1'b0; ctl_d.txd = 1'b0; ctl_d.pass = 1'b1; ctl_d.busy = 1'b0; end
            ST_LB_PULSE:  begin ctl_d.sd = 1'b1; ctl_d.txd = 1'b0; ctl_d.pass = 1'b0; ctl_d.busy = 1'b1; end
            ST_LB_HOLD:   begin ctl_d.sd = 1'b0; ctl_d.txd = 1'b0; ctl_d.pass = 1'b0; ctl_d.busy = 1'b1; end
            ST_HB_LEAD:   begin ctl_d.sd = 1'b1; ctl_d.txd = 1'b0; ctl_d.pass = 1'b0; ctl_d.busy = 1'b1; end
            ST_HB_SETUP:  begin ctl_d.sd = 1'b1; ctl_d.txd = 1'b1; ctl_d.pass = 1'b0; ctl_d.busy = 1'b1; end
            ST_HB_HOLD:   begin ctl_d.sd = 1'b0; ctl_d.txd = 1'b1; ctl_d.pass = 1'b0; ctl_d.busy = 1'b1; end
            ST_SLP_ENTER: begin ctl_d.sd = 1'b1; ctl_d.txd = 1'b0; ctl_d.pass = 1'b0; ctl_d.busy = 1'b1; end
            ST_ASLEEP:    begin ctl_d.sd = 1'b1; ctl_d.txd = 1'b0; ctl_d.pass = 1'b0; ctl_d.busy = 1'b0; end
            default:      begin ctl_d.sd = 1'b0; ctl_d.txd = 1'b0; ctl_d.pass = 1'b0; ctl_d.busy = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, sd: 1'b0, txd: 1'b0, pass: 1'b0,
                       busy: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    irx_txd_mux u_txd_mux (
        .pass_i  (ctl_q.pass),
        .drive_i (ctl_q.txd),
        .data_i  (tx_data_i),
        .txd_o   (txd_o)
    );

    assign sd_o   = ctl_q.sd;
    assign busy_o = ctl_q.busy;
    assign done_o = ctl_q.done;
    assign err_o  = ctl_q.err;
endmodule

// File: rtl/irx_modeseq_chk.sv
module irx_modeseq_chk #(
    parameter int unsigned PULSE_CYC = 11
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid_i,
    input logic sd_o,
    input logic txd_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);
    logic [31:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               hi_run_q <= '0;
        else if (!sd_o)           hi_run_q <= '0;
        else if (~&hi_run_q)      hi_run_q <= hi_run_q + 32'd1;
    end

    a_r12_txd_steady_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $fell(sd_o)) |-> (txd_o == $past(txd_o)));

    a_r12_pulse_wide_enough: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_o) |-> (hi_run_q >= PULSE_CYC));

    a_r10_err_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(req_valid_i));

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind irxcvr_modeseq irx_modeseq_chk #(.PULSE_CYC(C_PULSE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .sd_o        (sd_o),
    .txd_o       (txd_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/irxcvr_modeseq_tb.sv
`timescale 1ns/1ps
module irxcvr_modeseq_tb;
    localparam int unsigned PER   = 5;
    localparam int unsigned SLP_T = 1000;
    localparam int unsigned WK_T  = 500;
    localparam int SU   = 25 / PER + 1;
    localparam int HOLD = 100 / PER + 1;
    localparam int PUL  = 50 / PER + 1;
    localparam int SLP  = SLP_T / PER + 1;
    localparam int WK   = WK_T / PER + 1;
    localparam int LBP  = (PUL > SU) ? PUL : SU;
    localparam int LEAD = (PUL > 2 * SU) ? PUL - SU : SU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic tx_data = 1'b0;
    logic sd, txd, busy, done, err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irxcvr_modeseq #(.CLK_PERIOD_NS(PER), .SLEEP_NS(SLP_T), .WAKE_NS(WK_T)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
        .tx_data_i(tx_data), .sd_o(sd), .txd_o(txd), .busy_o(busy),
        .done_o(done), .err_o(err)
    );

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    function automatic string pins();
        return $sformatf("sd=%b txd=%b busy=%b done=%b err=%b", sd, txd, busy, done, err);
    endfunction

    // Checks n consecutive cycles against fixed levels, done and err low.
    task automatic seg(input string tag, input int n, input logic esd, input logic etxd,
                       input logic ebusy);
        int bad = 0;
        string first = "";
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sd !== esd || txd !== etxd || busy !== ebusy || done !== 1'b0 || err !== 1'b0) begin
                if (bad == 0) first = $sformatf("cycle %0d %s", i, pins());
                bad++;
            end
        end
        chk(bad == 0, tag, first,
            $sformatf("%0d cycles sd=%b txd=%b busy=%b done=0 err=0", n, esd, etxd, ebusy));
    endtask

    task automatic issue(input logic [1:0] op);
        req_valid = 1'b1;
        req_op = op;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic t_reset();
        tx_data = 1'b1;
        repeat (3) @(negedge clk);
        chk(sd === 0 && txd === 0 && busy === 0 && done === 0 && err === 0,
            "R1 reset levels", pins(), "all low");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_pass();
        for (int k = 0; k < 3; k++) begin
            tx_data = k[0];
            #1;
            chk(txd === k[0] && sd === 0, "R2 idle pass-through", pins(), $sformatf("txd=%b sd=0", k[0]));
            @(negedge clk);
        end
    endtask

    task automatic t_lowbw();
        @(negedge clk);
        tx_data = 1'b1;
        issue(2'd0);
        seg("R4 R6 R11 low-bw pulse", LBP, 1'b1, 1'b0, 1'b1);
        seg("R4 R6 R12 low-bw hold", HOLD, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk(done === 1 && busy === 0 && sd === 0 && txd === 1, "R9 R2 low-bw done", pins(),
            "done=1 busy=0 sd=0 txd=1");
        @(negedge clk);
        chk(done === 0, "R9 done single cycle", pins(), "done=0");
    endtask

    task automatic t_highbw_with_clash();
        @(negedge clk);
        tx_data = 1'b0;
        issue(2'd1);
        seg("R5 R3 high-bw lead", 2, 1'b1, 1'b0, 1'b1);
        issue(2'd0);
        @(negedge clk);
        chk(err === 1 && sd === 1 && txd === 0 && busy === 1, "R10 request while busy", pins(),
            "err=1 sd=1 txd=0 busy=1");
        seg("R5 R10 high-bw lead rest", LEAD - 3, 1'b1, 1'b0, 1'b1);
        seg("R5 R6 high-bw setup", SU, 1'b1, 1'b1, 1'b1);
        seg("R5 R12 high-bw hold", HOLD, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        chk(done === 1 && busy === 0 && txd === 0, "R5 R9 high-bw release", pins(),
            "done=1 busy=0 txd=0");
    endtask

    task automatic t_wake_idle();
        @(negedge clk);
        issue(2'd3);
        @(negedge clk);
        chk(err === 1 && busy === 0 && sd === 0, "R10 wake while idle", pins(), "err=1 busy=0 sd=0");
        tx_data = 1'b1;
        #1;
        chk(txd === 1 && err === 1, "R10 R2 idle unchanged", pins(), "txd=1");
    endtask

    task automatic t_sleep_wake();
        @(negedge clk);
        tx_data = 1'b1;
        issue(2'd2);
        seg("R7 R6 sleep entry", SLP, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk(done === 1 && busy === 0 && sd === 1 && txd === 0, "R7 R9 asleep", pins(),
            "done=1 busy=0 sd=1 txd=0");
        seg("R11 asleep blocks data", 4, 1'b1, 1'b0, 1'b0);
        issue(2'd1);
        @(negedge clk);
        chk(err === 1 && sd === 1 && busy === 0 && txd === 0, "R10 mode request asleep", pins(),
            "err=1 sd=1 busy=0 txd=0");
        seg("R10 still asleep", 2, 1'b1, 1'b0, 1'b0);
        issue(2'd3);
        seg("R8 R6 wake window", WK, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk(done === 1 && busy === 0 && sd === 0 && txd === 1, "R8 R9 awake idle", pins(),
            "done=1 busy=0 sd=0 txd=1");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_pass();
        t_lowbw();
        t_highbw_with_clash();
        t_wake_idle();
        t_sleep_wake();
        repeat (3) @(negedge clk);
        summary();
    end
endmodule